// File: doc/BRIEF.md
# Privilege Mode Decoder with Status Register

This block holds the processor status word and derives from it the current privilege level: kernel, supervisor or user. It also produces the access enables that other pipeline stages consume. Software updates the status word through a write port, and only the bits selected by a write mask can change. Three hardware events change the state on their own: exception entry, error/reset entry and debug entry. A debug-exit pulse ends the debug state.

The privilege level is computed combinationally from the registered status word and the registered debug flag. Every output is therefore valid in the cycle after the edge that captured a write or an event. The enables cover four things: system-coprocessor access, floating-point access, 64-bit operation, and the extended kernel and supervisor address regions. A parameter removes the 64-bit logic for 32-bit-only cores. A separate output carries the error-entry vector load and its fixed target address.

Top module: `priv_mode_ctrl`

## Requirements
- R1: After reset, the status word holds only ERL (bit 2) and BEV (bit 22), so it reads 0x0040_0004. The debug flag is clear, the mode is kernel (00) and vec_load is low.
- R2: A write with st_wr_en replaces exactly the bits set in the write mask with st_wr_data, one edge later. The default mask is 0x36F8_FFFF, and it must include bits 3 and 4. Bits outside the mask keep their value, except where R10 or R11 sets them.
- R3: The mode is user (10) when EXL (bit 1), ERL (bit 2) and the debug flag are all clear, bit 4 is set and bit 3 is clear.
- R4: The mode is supervisor (01) when EXL, ERL and the debug flag are all clear, bit 3 is set and bit 4 is clear.
- R5: In every other case the mode is kernel (00). This includes bits 3 and 4 both set, both clear, or any of EXL, ERL or debug set. The code 11 never appears.
- R6: cp0_ok is high when CU0 (bit 28) is set or the mode is kernel.
- R7: fpu_ok equals CU1 (bit 29).
- R8: wide_ok is high when the mode is not user, or when PX (bit 23) or UX (bit 5) is set.
- R9: kx_ok is high when the mode is kernel and KX (bit 7) is set. sx_ok is high when the mode is kernel or supervisor and SX (bit 6) is set.
- R10: exc_entry sets EXL at the next edge. It is applied on top of a write in the same cycle.
- R11: err_entry sets ERL and BEV at the next edge. vec_load is high for exactly the cycle after each err_entry, and vec_addr is 0xBFC0_0000.
- R12: dbg_entry sets the debug flag at the next edge, and dbg_exit clears it. When both are high, entry wins. Neither pulse changes the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_wr_en | input | 1 | Status write strobe |
| st_wr_data | input | 32 | Status write data |
| exc_entry | input | 1 | Exception entry pulse |
| err_entry | input | 1 | Error/reset entry pulse |
| dbg_entry | input | 1 | Debug entry pulse |
| dbg_exit | input | 1 | Debug exit pulse |
| status_q | output | 32 | Registered status word |
| mode | output | 2 | Privilege level: 00 kernel, 01 supervisor, 10 user |
| dbg_active | output | 1 | Debug flag |
| cp0_ok | output | 1 | System-coprocessor access enable |
| fpu_ok | output | 1 | Floating-point access enable |
| wide_ok | output | 1 | 64-bit operation enable |
| kx_ok | output | 1 | Extended kernel region enable |
| sx_ok | output | 1 | Extended supervisor region enable |
| vec_load | output | 1 | Error-entry vector load, one cycle |
| vec_addr | output | 32 | Error-entry vector address |

## Verification
A write, an event pulse or a debug pulse lands at the first rising edge after it is driven. The status word, the mode, all enables and vec_load reflect it from that edge on, with no further delay, because the enables are purely combinational on registered state. The bench drives each stimulus at a falling edge and advances its reference model at the following rising edge. It then compares every output at the next falling edge, which is exactly one edge after the stimulus and before the next one is applied. Directed steps cover each mode, the both-bits case and simultaneous events, and a long random stretch follows them.

// File: rtl/priv_pkg.sv
package priv_pkg;

   typedef enum logic [1:0] {
      PRIV_KERN = 2'b00,
      PRIV_SUPV = 2'b01,
      PRIV_USER = 2'b10
   } priv_mode_e;

   // status bit positions decoded by neighbouring logic
   localparam int ST_EXL = 1;
   localparam int ST_ERL = 2;
   localparam int ST_SUP = 3;
   localparam int ST_USR = 4;
   localparam int ST_UX  = 5;
   localparam int ST_SX  = 6;
   localparam int ST_KX  = 7;
   localparam int ST_BEV = 22;
   localparam int ST_PX  = 23;
   localparam int ST_CU0 = 28;
   localparam int ST_CU1 = 29;
   localparam int ST_TOP = 29;

endpackage

// File: rtl/priv_status_reg.sv
module priv_status_reg
   import priv_pkg::*;
#(
   parameter int          W       = 32,
   parameter logic [W-1:0] WR_MASK = 32'h36F8_FFFF,
   parameter logic [W-1:0] RST_VAL = 32'h0040_0004
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         exc_set,
   input  logic         err_set,
   input  logic         dbg_set,
   input  logic         dbg_clr,
   output logic [W-1:0] st_q,
   output logic         dbg_q,
   output logic         vec_q
);

   logic [W-1:0] merged;
   logic [W-1:0] st_d;

   always_comb begin
      merged = wr_en ? ((st_q & ~WR_MASK) | (wr_data & WR_MASK)) : st_q;
      st_d   = merged;
      if (exc_set) st_d[ST_EXL] = 1'b1;
      if (err_set) begin
         st_d[ST_ERL] = 1'b1;
         st_d[ST_BEV] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= RST_VAL;
         dbg_q <= 1'b0;
         vec_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         dbg_q <= dbg_set | (dbg_q & ~dbg_clr);
         vec_q <= err_set;
      end
   end

endmodule

// File: rtl/priv_mode_decode.sv
module priv_mode_decode
   import priv_pkg::*;
(
   input  logic       exl,
   input  logic       erl,
   input  logic       dbg,
   input  logic       usr_bit,
   input  logic       sup_bit,
   output priv_mode_e mode
);

   logic trapped;

   always_comb begin
      trapped = exl | erl | dbg;
      mode    = PRIV_KERN;
      if (!trapped) begin
         unique case ({usr_bit, sup_bit})
            2'b10:   mode = PRIV_USER;
            2'b01:   mode = PRIV_SUPV;
            default: mode = PRIV_KERN;
         endcase
      end
   end

endmodule

// File: rtl/priv_access_gate.sv
module priv_access_gate
   import priv_pkg::*;
#(
   parameter bit HAS_WIDE = 1'b1
) (
   input  priv_mode_e mode,
   input  logic       cu0,
   input  logic       cu1,
   input  logic       ux,
   input  logic       sx,
   input  logic       kx,
   input  logic       px,
   output logic       cp0_ok,
   output logic       fpu_ok,
   output logic       wide_ok,
   output logic       kx_ok,
   output logic       sx_ok
);

   logic is_kern;
   logic is_user;

   assign is_kern = (mode == PRIV_KERN);
   assign is_user = (mode == PRIV_USER);
   assign cp0_ok  = cu0 | is_kern;
   assign fpu_ok  = cu1;

   generate
      if (HAS_WIDE) begin : g_wide
         assign wide_ok = ~is_user | px | ux;
         assign kx_ok   = is_kern & kx;
         assign sx_ok   = ~is_user & sx;
      end else begin : g_narrow
         logic unused_ok;
         assign unused_ok = &{1'b0, ux, sx, kx, px};
         assign wide_ok   = 1'b0;
         assign kx_ok     = 1'b0;
         assign sx_ok     = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/priv_mode_ctrl.sv
module priv_mode_ctrl
   import priv_pkg::*;
#(
   parameter int           W         = 32,
   parameter logic [W-1:0] WR_MASK   = 32'h36F8_FFFF,
   parameter logic [W-1:0] RESET_VEC = 32'hBFC0_0000,
   parameter bit           HAS_WIDE  = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         st_wr_en,
   input  logic [W-1:0] st_wr_data,
   input  logic         exc_entry,
   input  logic         err_entry,
   input  logic         dbg_entry,
   input  logic         dbg_exit,
   output logic [W-1:0] status_q,
   output logic [1:0]   mode,
   output logic         dbg_active,
   output logic         cp0_ok,
   output logic         fpu_ok,
   output logic         wide_ok,
   output logic         kx_ok,
   output logic         sx_ok,
   output logic         vec_load,
   output logic [W-1:0] vec_addr
);

   localparam logic [W-1:0] RST_STATUS = (W'(1) << ST_ERL) | (W'(1) << ST_BEV);
   localparam logic [W-1:0] EVT_BITS   = (W'(1) << ST_ERL) | (W'(1) << ST_BEV) |
                                         (W'(1) << ST_EXL);
   localparam logic [W-1:0] HOLD_BITS  = ~(WR_MASK | EVT_BITS);

   generate
      if (W <= ST_TOP) begin : g_bad_width
         $error("priv_mode_ctrl: W too narrow for status fields");
      end
      if (!WR_MASK[ST_SUP] || !WR_MASK[ST_USR]) begin : g_bad_mask
         $error("priv_mode_ctrl: write mask must cover both mode bits");
      end
   endgenerate

   priv_mode_e mode_e;

   priv_status_reg #(
      .W       (W),
      .WR_MASK (WR_MASK),
      .RST_VAL (RST_STATUS)
   ) i_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (st_wr_en),
      .wr_data (st_wr_data),
      .exc_set (exc_entry),
      .err_set (err_entry),
      .dbg_set (dbg_entry),
      .dbg_clr (dbg_exit),
      .st_q    (status_q),
      .dbg_q   (dbg_active),
      .vec_q   (vec_load)
   );

   priv_mode_decode i_decode (
      .exl     (status_q[ST_EXL]),
      .erl     (status_q[ST_ERL]),
      .dbg     (dbg_active),
      .usr_bit (status_q[ST_USR]),
      .sup_bit (status_q[ST_SUP]),
      .mode    (mode_e)
   );

   priv_access_gate #(
      .HAS_WIDE (HAS_WIDE)
   ) i_gate (
      .mode    (mode_e),
      .cu0     (status_q[ST_CU0]),
      .cu1     (status_q[ST_CU1]),
      .ux      (status_q[ST_UX]),
      .sx      (status_q[ST_SX]),
      .kx      (status_q[ST_KX]),
      .px      (status_q[ST_PX]),
      .cp0_ok  (cp0_ok),
      .fpu_ok  (fpu_ok),
      .wide_ok (wide_ok),
      .kx_ok   (kx_ok),
      .sx_ok   (sx_ok)
   );

   assign mode     = mode_e;
   assign vec_addr = RESET_VEC;

   // R10
   exc_sets_exl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_entry |=> status_q[ST_EXL]);

   // R11
   err_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_entry |=> (status_q[ST_ERL] && status_q[ST_BEV] && vec_load));

   // R2
   unmasked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_q & HOLD_BITS) == $past(status_q & HOLD_BITS)));

   // R5
   trap_kernel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[ST_EXL] || status_q[ST_ERL] || dbg_active) |-> (mode == 2'b00));

   // R5
   mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 2'b11);

   // R6
   kernel_cp0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b00) |-> cp0_ok);

   // R12
   dbg_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_entry |=> dbg_active);

   // R12
   dbg_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_wr_en && !exc_entry && !err_entry) |=> $stable(status_q));

endmodule

// File: tb/test_priv_mode_ctrl.sv
module test_priv_mode_ctrl;

   localparam logic [31:0] MASK = 32'h36F8_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        st_wr_en = 1'b0;
   logic [31:0] st_wr_data = '0;
   logic        exc_entry = 1'b0;
   logic        err_entry = 1'b0;
   logic        dbg_entry = 1'b0;
   logic        dbg_exit = 1'b0;
   logic [31:0] status_q;
   logic [1:0]  mode;
   logic        dbg_active, cp0_ok, fpu_ok, wide_ok, kx_ok, sx_ok, vec_load;
   logic [31:0] vec_addr;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   logic [31:0] m_st;
   bit          m_dbg;
   bit          m_vec;

   always #5 clk = ~clk;

   priv_mode_ctrl i_priv_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
      .exc_entry(exc_entry), .err_entry(err_entry), .dbg_entry(dbg_entry),
      .dbg_exit(dbg_exit), .status_q(status_q), .mode(mode),
      .dbg_active(dbg_active), .cp0_ok(cp0_ok), .fpu_ok(fpu_ok),
      .wide_ok(wide_ok), .kx_ok(kx_ok), .sx_ok(sx_ok), .vec_load(vec_load),
      .vec_addr(vec_addr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [1:0] exp_mode();
      if (m_st[1] || m_st[2] || m_dbg) return 2'b00;
      if (m_st[4] && !m_st[3]) return 2'b10;
      if (m_st[3] && !m_st[4]) return 2'b01;
      return 2'b00;
   endfunction

   task automatic compare_all();
      logic [1:0] em;
      em = exp_mode();
      chk("R2/R10/R11 status", status_q, m_st);
      chk("R3/R4/R5 mode", {30'd0, mode}, {30'd0, em});
      chk("R12 debug", {31'd0, dbg_active}, {31'd0, m_dbg});
      chk("R6 cp0_ok", {31'd0, cp0_ok}, {31'd0, m_st[28] || em == 2'b00});
      chk("R7 fpu_ok", {31'd0, fpu_ok}, {31'd0, m_st[29]});
      chk("R8 wide_ok", {31'd0, wide_ok}, {31'd0, em != 2'b10 || m_st[23] || m_st[5]});
      chk("R9 kx_ok", {31'd0, kx_ok}, {31'd0, em == 2'b00 && m_st[7]});
      chk("R9 sx_ok", {31'd0, sx_ok}, {31'd0, em != 2'b10 && m_st[6]});
      chk("R11 vec_load", {31'd0, vec_load}, {31'd0, m_vec});
   endtask

   // drive at falling edge, model steps at rising edge, compare at next falling edge
   task automatic step(input bit wr, input logic [31:0] d, input bit ex,
                       input bit er, input bit de, input bit dx);
      st_wr_en = wr; st_wr_data = d; exc_entry = ex; err_entry = er;
      dbg_entry = de; dbg_exit = dx;
      @(posedge clk);
      if (wr) m_st = (m_st & ~MASK) | (d & MASK);
      if (ex) m_st[1] = 1'b1;
      if (er) begin m_st[2] = 1'b1; m_st[22] = 1'b1; end
      m_vec = er;
      if (de) m_dbg = 1'b1;
      else if (dx) m_dbg = 1'b0;
      @(negedge clk);
      compare_all();
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      m_st = 32'h0040_0004; m_dbg = 1'b0; m_vec = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 status", status_q, 32'h0040_0004);
      chk("R1 mode", {30'd0, mode}, 32'd0);
      chk("R1 debug", {31'd0, dbg_active}, 32'd0);
      chk("R1 vec_load", {31'd0, vec_load}, 32'd0);
      chk("R11 vec_addr", vec_addr, 32'hBFC0_0000);
      // R3 user, no 64-bit enable
      step(1, 32'h0000_0010, 0, 0, 0, 0);
      chk("R3 user", {30'd0, mode}, 32'd2);
      // R8 user with UX
      step(1, 32'h0000_0030, 0, 0, 0, 0);
      // R4 supervisor with SX and KX
      step(1, 32'h0000_00C8, 0, 0, 0, 0);
      chk("R4 supv", {30'd0, mode}, 32'd1);
      // R5 both mode bits set
      step(1, 32'h3000_0018, 0, 0, 0, 0);
      chk("R5 both", {30'd0, mode}, 32'd0);
      // R2 unmasked bits ignored
      step(1, 32'hFFFF_FFFF, 0, 0, 0, 0);
      step(1, 32'h0000_0010, 0, 0, 0, 0);
      // R10 exception with a write in the same cycle
      step(1, 32'h0000_0010, 1, 0, 0, 0);
      chk("R10 exl", {31'd0, status_q[1]}, 32'd1);
      step(1, 32'h0000_0008, 0, 0, 0, 0);
      // R12 debug entry and exit, entry wins when both
      step(0, 32'h0, 0, 0, 1, 0);
      step(0, 32'h0, 0, 0, 1, 1);
      step(0, 32'h0, 0, 0, 0, 1);
      chk("R12 exit", {31'd0, dbg_active}, 32'd0);
      // R11 error entry and one-cycle vector load
      step(0, 32'h0, 0, 1, 0, 0);
      chk("R11 load", {31'd0, vec_load}, 32'd1);
      step(0, 32'h0, 0, 0, 0, 0);
      chk("R11 pulse", {31'd0, vec_load}, 32'd0);
      for (int i = 0; i < 2000; i++) begin
         logic [31:0] r;
         r = $urandom;
         step(r[0] | r[1], $urandom, (r[4:2] == 3'd0), (r[7:5] == 3'd0),
              (r[10:8] == 3'd0), (r[13:11] == 3'd0));
      end
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule